// File: doc/BRIEF.md
# Coalescing Write Buffer with Read Bypass

This block sits between a write-through data cache and the next level of memory. Every store the processor issues enters the buffer as a word write into a block-sized entry. The entry holds a block address, four 32-bit words and a byte-valid mask. A store whose block is already held by an entry that is not being drained is merged into that entry, so bursts of stores to nearby addresses use up few slots. Entries leave in allocation order as single-beat block writes on the memory port. This drain runs in the background while new stores keep arriving.

Loads probe the buffer without waiting. The probe is combinational. If the buffered entries for the block hold every requested byte, the probe reports a hit and returns the newest buffered bytes. If they hold only some of the requested bytes, it reports a conflict, and the cache must hold the load until the entry has drained. A read miss that needs memory is given the port ahead of queued writes. The one exception is a write already offered on the port: that write stays there until it is accepted.

All addresses are word addresses. The low two bits select the word in a block, and the remaining bits form the block address. In a block-wide vector, byte b of word w sits at byte lane 4*w+b, which is bits 8*(4*w+b) and up in the data and bit 4*w+b in the mask. Store input, read request and memory port follow valid/ready rules: a transfer happens on a cycle where both are high. The store input may drop ready at any time, and the buffer holds an offered memory request stable until the memory accepts it.

Top module: `cwb_top`

## Requirements
- R1: After reset the buffer is empty: st_ready is high, mem_valid is low, and a probe reports neither hit nor conflict.
- R2: Buffered entries are written to memory in the order they were allocated, one beat per entry, carrying the block address on mem_addr, the bytes on mem_wdata and the byte-valid mask on mem_wmask (lane 4*w+b is byte b of word w), with mem_write high.
- R3: A store to a block held by an entry that is not being offered on the memory port overwrites the enabled bytes of that entry and ORs them into its mask without using a new slot.
- R4: With all DEPTH entries in use, st_ready is low for a store that matches no mergeable entry, and high for a store that does.
- R5: Draining proceeds concurrently with stores: a store can be accepted in the same cycle in which a buffered write completes its handshake.
- R6: A probe whose requested bytes (ld_be) are all present in buffered entries of its block reports ld_hit and returns on ld_data the bytes from the youngest entry holding each one; unrequested bytes read as zero.
- R7: A probe that finds its block buffered but with some requested byte missing reports ld_conflict and not ld_hit.
- R8: When rd_valid is high and no write is still waiting for acceptance from the previous cycle, the read request takes the memory port (mem_write low, mem_addr equal to rd_addr), and rd_ready follows mem_ready.
- R9: A request offered with mem_valid high and mem_ready low is offered again unchanged in the next cycle.
- R10: The entry being offered on the memory port is locked: a store to its block allocates a new entry, and the offered bytes and mask are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | WADDR_W | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| ld_valid | input | 1 | Load probe active |
| ld_addr | input | WADDR_W | Load word address |
| ld_be | input | 4 | Bytes requested by the load |
| ld_hit | output | 1 | All requested bytes are buffered |
| ld_conflict | output | 1 | Block buffered but some requested bytes missing |
| ld_data | output | 32 | Forwarded bytes on hit |
| rd_valid | input | 1 | Read miss request valid |
| rd_ready | output | 1 | Read miss request accepted |
| rd_addr | input | WADDR_W-2 | Read miss block address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 for buffered block write, 0 for read |
| mem_addr | output | WADDR_W-2 | Block address of request |
| mem_wdata | output | 128 | Block write data |
| mem_wmask | output | 16 | Byte-valid mask of block write |

## Verification
On every cycle, the assertions check that an offered memory request and its write payload stay frozen until accepted, that a write appears beside a pending read only when that write was already waiting, that a probe never signals hit and conflict together, that a merge consumes no slot, and that only a valid head entry is ever popped. The content of the traffic cannot be shown that way: merged bytes, drain order, youngest-entry forwarding, and new allocation behind a locked head. For these the bench scenarios keep their own model of the queue and compare each write beat and each probe result against it. The scenarios include a full buffer under back-pressure and random mixes of stores, probes and read misses.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int WORD_W        = 32;
  localparam int LANE_W        = WORD_W / 8;
  localparam int WORDS_PER_BLK = 4;
  localparam int WSEL_W        = $clog2(WORDS_PER_BLK);
  localparam int BLK_BYTES     = WORDS_PER_BLK * LANE_W;
  localparam int BLK_BITS      = WORDS_PER_BLK * WORD_W;
endpackage

// File: rtl/cwb_entries.sv
module cwb_entries
  import cwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK_W = 28,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               st_valid,
  input  logic [BLK_W-1:0]                   st_blk,
  input  logic [WSEL_W-1:0]                  st_word,
  input  logic [WORD_W-1:0]                  st_data,
  input  logic [LANE_W-1:0]                  st_be,
  output logic                               st_ready,
  input  logic                               head_lock,
  input  logic                               pop,
  output logic [DEPTH-1:0]                   ent_vld,
  output logic [DEPTH-1:0][BLK_W-1:0]        ent_blk,
  output logic [DEPTH-1:0][BLK_BITS-1:0]     ent_data,
  output logic [DEPTH-1:0][BLK_BYTES-1:0]    ent_mask,
  output logic [PTR_W-1:0]                   head_ptr
);
  logic [PTR_W-1:0]     tail_ptr, hit_idx;
  logic [CNT_W-1:0]     count;
  logic                 hit_any, full, st_fire, do_alloc;
  logic [BLK_BYTES-1:0] lane_mask;
  logic [BLK_BITS-1:0]  lane_data, bit_mask;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && ent_blk[i] == st_blk &&
          !(head_lock && PTR_W'(i) == head_ptr)) begin
        hit_any = 1'b1;
        hit_idx = PTR_W'(i);
      end
    end
  end

  assign full      = (count == CNT_W'(DEPTH));
  assign st_ready  = hit_any || !full;
  assign st_fire   = st_valid && st_ready;
  assign do_alloc  = st_fire && !hit_any;
  assign lane_mask = BLK_BYTES'(st_be) << (st_word * LANE_W);
  assign lane_data = BLK_BITS'(st_data) << (st_word * WORD_W);

  always_comb begin
    for (int j = 0; j < BLK_BYTES; j++) bit_mask[j*8 +: 8] = {8{lane_mask[j]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (pop) begin
        ent_vld[head_ptr] <= 1'b0;
        head_ptr          <= ptr_next(head_ptr);
      end
      if (do_alloc) begin
        ent_vld[tail_ptr] <= 1'b1;
        tail_ptr          <= ptr_next(tail_ptr);
      end
      count <= count + CNT_W'(do_alloc) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      ent_blk[tail_ptr]  <= st_blk;
      ent_mask[tail_ptr] <= lane_mask;
      ent_data[tail_ptr] <= lane_data & bit_mask;
    end else if (st_fire) begin
      ent_mask[hit_idx] <= ent_mask[hit_idx] | lane_mask;
      ent_data[hit_idx] <= (ent_data[hit_idx] & ~bit_mask) | (lane_data & bit_mask);
    end
  end

  // R3: a merge leaves the occupancy unchanged
  assert_merge_keeps_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && hit_any && !pop) |=> (count == $past(count)));

  // R2: the drain side only ever removes a valid head entry
  assert_pop_valid_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ent_vld[head_ptr]);

  // R4: occupancy never exceeds the depth
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (count == CNT_W'(DEPTH)) || $past(st_fire && hit_any) || !$past(st_fire));
endmodule

// File: rtl/cwb_probe.sv
module cwb_probe
  import cwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLK_W = 28,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            ld_valid,
  input  logic [BLK_W-1:0]                ld_blk,
  input  logic [WSEL_W-1:0]               ld_word,
  input  logic [LANE_W-1:0]               ld_be,
  input  logic [DEPTH-1:0]                ent_vld,
  input  logic [DEPTH-1:0][BLK_W-1:0]     ent_blk,
  input  logic [DEPTH-1:0][BLK_BITS-1:0]  ent_data,
  input  logic [DEPTH-1:0][BLK_BYTES-1:0] ent_mask,
  input  logic [PTR_W-1:0]                head_ptr,
  output logic                            ld_hit,
  output logic                            ld_conflict,
  output logic [WORD_W-1:0]               ld_data
);
  logic              any_match, all_cov;
  logic [LANE_W-1:0] cov;
  logic [WORD_W-1:0] gathered;

  // walk from oldest to youngest so younger bytes win
  always_comb begin
    logic [PTR_W-1:0]  idx;
    logic [WORD_W-1:0] wsel;
    logic [LANE_W-1:0] msel;
    any_match = 1'b0;
    cov       = '0;
    gathered  = '0;
    idx       = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      wsel = WORD_W'(ent_data[idx] >> (ld_word * WORD_W));
      msel = LANE_W'(ent_mask[idx] >> (ld_word * LANE_W));
      if (ent_vld[idx] && ent_blk[idx] == ld_blk) begin
        any_match = 1'b1;
        for (int b = 0; b < LANE_W; b++) begin
          if (msel[b]) begin
            cov[b]            = 1'b1;
            gathered[b*8 +: 8] = wsel[b*8 +: 8];
          end
        end
      end
      idx = (idx == PTR_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
    end
  end

  assign all_cov     = ((cov & ld_be) == ld_be);
  assign ld_hit      = ld_valid && any_match && all_cov;
  assign ld_conflict = ld_valid && any_match && !all_cov;

  always_comb begin
    ld_data = '0;
    for (int b = 0; b < LANE_W; b++)
      if (ld_hit && ld_be[b]) ld_data[b*8 +: 8] = gathered[b*8 +: 8];
  end
endmodule

// File: rtl/cwb_arb.sv
module cwb_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic wr_pending,
  input  logic mem_ready,
  output logic rd_sel,
  output logic wr_sel
);
  logic wr_hold;

  always_comb begin
    wr_sel = wr_pending && (wr_hold || !rd_valid);
    rd_sel = rd_valid && !wr_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_hold <= 1'b0;
    else        wr_hold <= wr_sel && !mem_ready;
  end

  // R8/R9: the port never carries both kinds of request
  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_sel && wr_sel));

  // R9: a write left waiting stays granted next cycle
  assert_hold_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !mem_ready) |=> wr_sel);
endmodule

// File: rtl/cwb_top.sv
module cwb_top
  import cwb_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DEPTH   = 8,
  localparam int BLK_W  = WADDR_W - WSEL_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [WADDR_W-1:0]   st_addr,
  input  logic [WORD_W-1:0]    st_data,
  input  logic [LANE_W-1:0]    st_be,
  input  logic                 ld_valid,
  input  logic [WADDR_W-1:0]   ld_addr,
  input  logic [LANE_W-1:0]    ld_be,
  output logic                 ld_hit,
  output logic                 ld_conflict,
  output logic [WORD_W-1:0]    ld_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [BLK_W-1:0]     rd_addr,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_write,
  output logic [BLK_W-1:0]     mem_addr,
  output logic [BLK_BITS-1:0]  mem_wdata,
  output logic [BLK_BYTES-1:0] mem_wmask
);
  logic [DEPTH-1:0]                   ent_vld;
  logic [DEPTH-1:0][BLK_W-1:0]        ent_blk;
  logic [DEPTH-1:0][BLK_BITS-1:0]     ent_data;
  logic [DEPTH-1:0][BLK_BYTES-1:0]    ent_mask;
  logic [PTR_W-1:0]                   head_ptr;
  logic                               rd_sel, wr_sel, pop;

  assign pop = wr_sel && mem_ready;

  cwb_entries #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_blk(st_addr[WADDR_W-1:WSEL_W]),
    .st_word(st_addr[WSEL_W-1:0]), .st_data(st_data), .st_be(st_be),
    .st_ready(st_ready), .head_lock(wr_sel), .pop(pop),
    .ent_vld(ent_vld), .ent_blk(ent_blk), .ent_data(ent_data),
    .ent_mask(ent_mask), .head_ptr(head_ptr)
  );

  cwb_probe #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_probe (
    .ld_valid(ld_valid), .ld_blk(ld_addr[WADDR_W-1:WSEL_W]),
    .ld_word(ld_addr[WSEL_W-1:0]), .ld_be(ld_be),
    .ent_vld(ent_vld), .ent_blk(ent_blk), .ent_data(ent_data),
    .ent_mask(ent_mask), .head_ptr(head_ptr),
    .ld_hit(ld_hit), .ld_conflict(ld_conflict), .ld_data(ld_data)
  );

  cwb_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .wr_pending(ent_vld[head_ptr]), .mem_ready(mem_ready),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  assign mem_valid = rd_sel || wr_sel;
  assign mem_write = wr_sel;
  assign mem_addr  = wr_sel ? ent_blk[head_ptr] : rd_addr;
  assign mem_wdata = wr_sel ? ent_data[head_ptr] : '0;
  assign mem_wmask = wr_sel ? ent_mask[head_ptr] : '0;
  assign rd_ready  = rd_sel && mem_ready;

  // R9: an offered request is repeated unchanged until accepted
  assert_offer_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) && $stable(mem_addr)));

  // R10: the locked head is not altered while it waits on the port
  assert_locked_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_ready) |=> ($stable(mem_wdata) && $stable(mem_wmask)));

  // R8: a write sits beside a pending read only if it was already waiting
  assert_read_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mem_valid && mem_write) |-> $past(mem_valid && mem_write && !mem_ready));

  // R7: hit and conflict are mutually exclusive
  assert_probe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_conflict));
endmodule

// File: tb/cwb_top_test.sv
module cwb_top_test;
  localparam int DEPTH = 8;
  localparam int WAW   = 30;
  localparam int BW    = WAW - 2;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            st_valid = 0, st_ready;
  logic [WAW-1:0]  st_addr = '0;
  logic [31:0]     st_data = '0;
  logic [3:0]      st_be = '0;
  logic            ld_valid = 0, ld_hit, ld_conflict;
  logic [WAW-1:0]  ld_addr = '0;
  logic [3:0]      ld_be = '0;
  logic [31:0]     ld_data;
  logic            rd_valid = 0, rd_ready;
  logic [BW-1:0]   rd_addr = '0;
  logic            mem_valid, mem_ready = 0, mem_write;
  logic [BW-1:0]   mem_addr;
  logic [127:0]    mem_wdata;
  logic [15:0]     mem_wmask;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model of the queue, oldest at index 0
  logic [BW-1:0]  m_blk[DEPTH];
  logic [127:0]   m_data[DEPTH];
  logic [15:0]    m_mask[DEPTH];
  int             m_cnt = 0;
  bit             prev_hold = 0, rd_acc = 0;
  logic [BW-1:0]  prev_addr;
  logic [127:0]   prev_data;

  always #2 clk = ~clk;

  cwb_top #(.WADDR_W(WAW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_conflict(ld_conflict), .ld_data(ld_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
  );

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected probe result from the model: {hit, conflict, data}
  function automatic logic [33:0] probe_exp(input logic [WAW-1:0] a, input logic [3:0] be);
    logic [3:0]  cov = '0;
    logic [31:0] d = '0;
    bit any = 0;
    for (int e = 0; e < m_cnt; e++) begin
      if (m_blk[e] == a[WAW-1:2]) begin
        any = 1;
        for (int b = 0; b < 4; b++) begin
          if (m_mask[e][a[1:0]*4 + b]) begin
            cov[b] = 1'b1;
            d[b*8 +: 8] = m_data[e][(a[1:0]*4 + b)*8 +: 8];
          end
        end
      end
    end
    for (int b = 0; b < 4; b++) if (!be[b]) d[b*8 +: 8] = 8'h00;
    if (!any) return 34'b0;
    if ((cov & be) == be) return {1'b1, 1'b0, d};
    return {1'b0, 1'b1, 32'h0};
  endfunction

  task automatic step(input bit sv, input logic [WAW-1:0] sa, input logic [31:0] sd,
                      input logic [3:0] sbe, input bit lv, input logic [WAW-1:0] la,
                      input logic [3:0] lbe, input bit mr, input bit rv);
    bit exp_wr;
    int midx;
    logic [33:0] pe;
    @(negedge clk);
    if (rd_acc) rd_valid = 0;
    rd_acc = 0;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe;
    ld_valid = lv; ld_addr = la; ld_be = lbe; mem_ready = mr;
    if (!rd_valid && rv) begin
      rd_valid = 1;
      rd_addr  = BW'(28'h00ABC00 + $urandom_range(0, 15));
    end
    #1;
    exp_wr = (m_cnt > 0) && (prev_hold || !rd_valid);
    if (prev_hold)
      chk("R9 held request repeated", {mem_valid, mem_write, mem_addr, mem_wdata},
          {1'b1, 1'b1, prev_addr, prev_data});
    if (rd_valid && !prev_hold)
      chk("R8 read takes port", {mem_valid, mem_write, mem_addr, rd_ready},
          {1'b1, 1'b0, rd_addr, mem_ready});
    if (!rd_valid)
      chk("R2 background drain offer", {mem_valid, mem_write}, {exp_wr, exp_wr});
    if (mem_valid && mem_write && m_cnt > 0)
      chk("R2/R3/R10 drained block", {mem_addr, mem_wdata, mem_wmask},
          {m_blk[0], m_data[0], m_mask[0]});
    midx = -1;
    for (int e = 0; e < m_cnt; e++)
      if (m_blk[e] == sa[WAW-1:2] && !(exp_wr && e == 0)) midx = e;
    if (sv)
      chk("R4/R5/R10 store ready", st_ready, (midx >= 0) || (m_cnt < DEPTH));
    if (lv) begin
      pe = probe_exp(la, lbe);
      chk("R6/R7 probe result", {ld_hit, ld_conflict, ld_data}, pe);
    end
    // model update: store first, then drain pop
    if (sv && st_ready) begin
      if (midx < 0) begin
        midx = m_cnt;
        m_cnt++;
        m_blk[midx] = sa[WAW-1:2];
        m_data[midx] = '0;
        m_mask[midx] = '0;
      end
      for (int b = 0; b < 4; b++) begin
        if (sbe[b]) begin
          m_mask[midx][sa[1:0]*4 + b] = 1'b1;
          m_data[midx][(sa[1:0]*4 + b)*8 +: 8] = sd[b*8 +: 8];
        end
      end
    end
    if (mem_valid && mem_write && mem_ready && m_cnt > 0) begin
      for (int e = 0; e < DEPTH - 1; e++) begin
        m_blk[e] = m_blk[e+1]; m_data[e] = m_data[e+1]; m_mask[e] = m_mask[e+1];
      end
      m_cnt--;
    end
    if (rd_valid && rd_ready) rd_acc = 1;
    prev_hold = mem_valid && mem_write && !mem_ready;
    prev_addr = mem_addr;
    prev_data = mem_wdata;
  endtask

  function automatic logic [WAW-1:0] wa(input int blk, input int w);
    return {BW'(blk), 2'(w)};
  endfunction

  task automatic drain();
    for (int n = 0; n < 40 && (m_cnt > 0 || rd_valid); n++)
      step(0, '0, '0, '0, 0, '0, '0, 1, 0);
  endtask

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ld_valid = 1; ld_addr = wa(16'h100, 0); ld_be = 4'hF;
    #1;
    // R1: empty after reset
    chk("R1 reset state", {st_ready, mem_valid, ld_hit, ld_conflict}, 4'b1000);
    ld_valid = 0;

    // fill with distinct blocks while memory stalls (R4)
    for (int i = 0; i < DEPTH; i++)
      step(1, wa(16'h200 + i, 0), 32'h11110000 + i, 4'hF, 0, '0, '0, 0, 0);
    step(1, wa(16'h2F0, 1), 32'hDEADBEEF, 4'hF, 0, '0, '0, 0, 0);   // R4 refused
    step(1, wa(16'h203, 2), 32'hCAFEF00D, 4'h6, 0, '0, '0, 0, 0);   // R3/R4 merge when full
    step(1, wa(16'h200, 1), 32'h0BAD0BAD, 4'hF, 0, '0, '0, 0, 0);   // R10 head locked, full
    step(0, '0, '0, '0, 1, wa(16'h203, 2), 4'h6, 0, 0);             // R6 hit on merged bytes
    step(0, '0, '0, '0, 1, wa(16'h203, 2), 4'hF, 0, 0);             // R7 partial
    step(0, '0, '0, '0, 1, wa(16'h203, 1), 4'h1, 0, 0);             // R7 word missing
    // R5: store accepted in the cycle a write completes
    step(1, wa(16'h205, 3), 32'h55AA55AA, 4'hF, 0, '0, '0, 1, 0);
    step(1, wa(16'h300, 0), 32'h12345678, 4'hF, 0, '0, '0, 1, 0);
    drain();

    // R10: store to the offered head goes to a new entry
    step(1, wa(16'h400, 0), 32'hA0A0A0A0, 4'hF, 0, '0, '0, 0, 0);
    step(1, wa(16'h400, 1), 32'hB1B1B1B1, 4'hF, 0, '0, '0, 0, 0);
    step(1, wa(16'h400, 2), 32'hC2C2C2C2, 4'h3, 0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 1, wa(16'h400, 1), 4'hF, 0, 0);             // R6 youngest entry
    step(0, '0, '0, '0, 0, '0, '0, 0, 1);                           // R8/R9 write held vs read
    drain();

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int blk = 16'h100 + $urandom_range(0, 9);
      step($urandom_range(0, 99) < 60, wa(blk, $urandom_range(0, 3)), $urandom,
           4'($urandom_range(1, 15)),
           $urandom_range(0, 99) < 50, wa(16'h100 + $urandom_range(0, 9), $urandom_range(0, 3)),
           4'($urandom_range(1, 15)),
           $urandom_range(0, 99) < 35, $urandom_range(0, 99) < 15);
    end
    drain();
    chk("R2 buffer emptied", {mem_valid, 31'(m_cnt)}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule